// File: doc/BRIEF.md
# Overflow Interrupt Decimator

This block sits between a timer's overflow output and the interrupt status logic. It thins out overflow interrupts: instead of raising an event on every overflow, it raises one qualified event and then lets a programmed number of overflows go by silently before it raises the next. Software sets the number of silent overflows through a wrap register. It can also read or preset the running overflow count through a second register. Both registers sit on a simple single-cycle register bus.

The running count and the wrap value are each 24 bits wide. On the 32-bit bus they read with the upper byte zero. With a wrap value of W, the event fires on one overflow in every W+1. A wrap value of zero therefore passes every overflow through.

Top module: `ovfm_top`

## Requirements
- R1: After reset, both registers read 0x00000000 and `irq_evt` is low.
- R2: Bus bits 31:24 always read as zero for both registers. Writes to those bits have no effect. With `bus_sel` = 0 the count register is selected; with `bus_sel` = 1 the wrap register is selected.
- R3: On an `ovf_pulse` cycle in which the count equals the wrap value, `irq_evt` is high for exactly the following cycle and the count becomes zero.
- R4: On an `ovf_pulse` cycle in which the count differs from the wrap value, the count increases by one modulo 2^24 and `irq_evt` stays low in the following cycle.
- R5: With a wrap value of zero and a count of zero, every overflow pulse produces an event.
- R6: A count-register write in the same cycle as an overflow pulse sets the count to the written value. The event decision for that pulse is still taken on the count held before the write.
- R7: With wrap value W and a count starting at zero, events occur on overflows W+1, 2(W+1), and so on, counted from the first pulse. The wrap value changes only on a bus write to it.
- R8: `irq_evt` is never high unless `ovf_pulse` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovf_pulse | input | 1 | One-cycle overflow indication from the timer |
| bus_wr_en | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 count, 1 wrap |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_evt | output | 1 | Qualified overflow event, one cycle, registered |

## Verification
The assertions assume that `ovf_pulse` and the bus signals are synchronous to `clk` and are known after reset. They also assume that a change of the wrap value reaches the compare in the next cycle. The bench drives every input on the falling edge, so each pulse and each write is seen at exactly one rising edge. It sweeps wrap values 0 to 6 over three full periods each, with the count preset to zero, so every compare is taken against a count that the model can predict. It also uses directed cases for a write coinciding with a pulse, for a full-width write, and for a count that wraps past 2^24-1.

// File: rtl/ovfm_pkg.sv
package ovfm_pkg;
   // Register select encoding on the bus
   typedef enum logic {
      SEL_COUNT = 1'b0,
      SEL_WRAP  = 1'b1
   } ovfm_sel_e;

   localparam int unsigned OVFM_BUS_W = 32;
   localparam int unsigned OVFM_CNT_W = 24;
endpackage

// File: rtl/ovfm_regs.sv
module ovfm_regs
   import ovfm_pkg::*;
#(
   parameter int unsigned BUS_W = OVFM_BUS_W,
   parameter int unsigned CNT_W = OVFM_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             sel_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] wrap_o,
   output logic             cnt_wr_o,
   output logic [CNT_W-1:0] cnt_wdata_o,
   output logic [BUS_W-1:0] rdata_o
);
   localparam int unsigned PAD_W = BUS_W - CNT_W;

   logic [CNT_W-1:0] wrap_q;
   logic             wrap_wr;
   logic [CNT_W-1:0] sel_field;

   assign wrap_wr     = wr_en_i && (ovfm_sel_e'(sel_i) == SEL_WRAP);
   assign cnt_wr_o    = wr_en_i && (ovfm_sel_e'(sel_i) == SEL_COUNT);
   assign cnt_wdata_o = wdata_i[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wrap_q <= '0;
      else if (wrap_wr) wrap_q <= wdata_i[CNT_W-1:0];
   end

   assign wrap_o    = wrap_q;
   assign sel_field = (ovfm_sel_e'(sel_i) == SEL_WRAP) ? wrap_q : cnt_i;

   generate
      if (PAD_W > 0) begin : g_pad
         logic unused_hi_bits;
         assign unused_hi_bits = ^wdata_i[BUS_W-1:CNT_W];
         assign rdata_o = {{PAD_W{1'b0}}, sel_field};
      end else begin : g_nopad
         assign rdata_o = sel_field;
      end
   endgenerate

   // R7
   wrap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_wr |=> $stable(wrap_q));
   // R2
   wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_wr |=> wrap_q == $past(wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/ovfm_counter.sv
module ovfm_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] wrap_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             evt_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             evt_q, hit;

   assign hit = (cnt_q == wrap_i);

   always_comb begin
      cnt_d = cnt_q;
      if (wr_i)       cnt_d = wdata_i;
      else if (ovf_i) cnt_d = hit ? '0 : cnt_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         evt_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         evt_q <= ovf_i && hit;
      end
   end

   assign cnt_o = cnt_q;
   assign evt_o = evt_q;

   // R3
   match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && !wr_i && cnt_q == wrap_i) |=> (cnt_q == '0 && evt_q));
   // R4
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && !wr_i && cnt_q != wrap_i) |=> (cnt_q == $past(cnt_q) + ONE && !evt_q));
   // R6
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> cnt_q == $past(wdata_i));
   // R8
   evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> $past(ovf_i));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_i && !wr_i) |=> ($stable(cnt_q) && !evt_q));
endmodule

// File: rtl/ovfm_top.sv
module ovfm_top
   import ovfm_pkg::*;
#(
   parameter int unsigned BUS_W = OVFM_BUS_W,
   parameter int unsigned CNT_W = OVFM_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf_pulse,
   input  logic             bus_wr_en,
   input  logic             bus_sel,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq_evt
);
   generate
      if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_width
         $error("ovfm_top: CNT_W must lie in 1..BUS_W");
      end
   endgenerate

   logic [CNT_W-1:0] wrap_v, cnt_v, cnt_wdata;
   logic             cnt_wr;

   ovfm_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (bus_wr_en),
      .sel_i       (bus_sel),
      .wdata_i     (bus_wdata),
      .cnt_i       (cnt_v),
      .wrap_o      (wrap_v),
      .cnt_wr_o    (cnt_wr),
      .cnt_wdata_o (cnt_wdata),
      .rdata_o     (bus_rdata)
   );

   ovfm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ovf_i   (ovf_pulse),
      .wr_i    (cnt_wr),
      .wdata_i (cnt_wdata),
      .wrap_i  (wrap_v),
      .cnt_o   (cnt_v),
      .evt_o   (irq_evt)
   );
endmodule

// File: tb/ovfm_top_tb.sv
module ovfm_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ovf_pulse = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic        bus_sel = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_evt;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ovfm_top u_dut (
      .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse),
      .bus_wr_en(bus_wr_en), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_evt(irq_evt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel, input string req, input logic [31:0] exp);
      bus_sel = sel;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   // one pulse; returns event seen in the cycle after the pulse
   task automatic pulse(output logic ev);
      @(negedge clk);
      ovf_pulse = 1'b1;
      @(negedge clk);
      ovf_pulse = 1'b0;
      ev = irq_evt;
   endtask

   initial begin
      logic ev;
      int   model;
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hang expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic ev;
      int   model;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'b0, irq_evt}, 32'h0);
      rd(1'b0, "R1 count", 32'h0);
      rd(1'b1, "R1 wrap", 32'h0);

      // R2 upper byte ignored and reads zero
      wr(1'b1, 32'hFF00_0005);
      rd(1'b1, "R2 wrap", 32'h0000_0005);
      wr(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, "R2 count", 32'h00FF_FFFF);
      // R4 wrap past 2^24-1 when count != wrap
      pulse(ev);
      chk("R4 wrap-around evt", {31'b0, ev}, 32'h0);
      rd(1'b0, "R4 wrap-around count", 32'h0);

      // R5 wrap zero: every pulse is an event
      wr(1'b1, 32'h0);
      wr(1'b0, 32'h0);
      for (int k = 0; k < 4; k++) begin
         pulse(ev);
         chk("R5 evt", {31'b0, ev}, 32'h1);
      end

      // R3 R4 R7 sweep of wrap values
      for (int w = 0; w <= 6; w++) begin
         wr(1'b1, w);
         wr(1'b0, 32'h0);
         model = 0;
         for (int k = 1; k <= 3 * (w + 1); k++) begin
            pulse(ev);
            chk("R7 period", {31'b0, ev}, {31'b0, (k % (w + 1)) == 0});
            model = (model == w) ? 0 : model + 1;
            rd(1'b0, "R3 R4 count", model);
         end
      end

      // R6 write coinciding with a matching pulse
      wr(1'b1, 32'h0);
      wr(1'b0, 32'h0);
      @(negedge clk);
      ovf_pulse = 1'b1; bus_wr_en = 1'b1; bus_sel = 1'b0; bus_wdata = 32'h7;
      @(negedge clk);
      ovf_pulse = 1'b0; bus_wr_en = 1'b0;
      chk("R6 evt on old count", {31'b0, irq_evt}, 32'h1);
      rd(1'b0, "R6 count written", 32'h7);
      // R6 write coinciding with a non-matching pulse
      wr(1'b1, 32'h3);
      wr(1'b0, 32'h1);
      @(negedge clk);
      ovf_pulse = 1'b1; bus_wr_en = 1'b1; bus_sel = 1'b0; bus_wdata = 32'h9;
      @(negedge clk);
      ovf_pulse = 1'b0; bus_wr_en = 1'b0;
      chk("R6 no evt", {31'b0, irq_evt}, 32'h0);
      rd(1'b0, "R6 count 9", 32'h9);

      // R8 idle: no event, state held
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R8 idle evt", {31'b0, irq_evt}, 32'h0);
      end
      rd(1'b0, "R8 idle count", 32'h9);
      rd(1'b1, "R7 wrap held", 32'h3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #20 rst_n = 1'b1;
   end
endmodule